// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter

This block turns a stream of stereo audio sample pairs into a single biphase-mark coded line signal in the consumer/professional digital audio interface format (S/PDIF / AES3 style). It runs on a clock at twice the bit-cell rate, so one clock cycle is one half-cell. Each subframe is 32 cells (64 clocks). A frame is a left subframe followed by a right subframe. A block is 384 subframes, numbered 0 to 383.

Samples arrive as left/right pairs over a valid/ready handshake. A single holding register takes one pair. That pair is used when the next left subframe begins. Two 384-entry one-bit memories supply the channel-status bit and the user bit of every subframe, indexed by the subframe number within the block. Software-free write ports fill the memories. Two level inputs give the validity flag sent in left and in right subframes. When no pair is ready at the start of a frame, the frame carries silence marked invalid, and a one-clock underrun pulse is raised.

Top module: `spdif_bmc_tx`

## Requirements
- R1: The line changes level at the start of every cell. This covers the first half-cell of each preamble and cells 4 to 31 of every subframe.
- R2: In cells 4 to 31, the line changes level again at mid-cell exactly when the cell's bit is 1.
- R3: The preamble fills half-cells 0 to 7 of a subframe. Read in time order, with the line low before it, the patterns are X = 11100010, Y = 11100100 and Z = 11101000. With the line high before it, the pattern is inverted.
- R4: Subframe 0 of each block uses Z. Every other even-numbered (left) subframe uses X. Every odd-numbered (right) subframe uses Y.
- R5: Cells 4 to 27 carry the 24-bit sample, least significant bit first. The left sample goes in the even subframe and the right sample of the same pair goes in the following odd subframe.
- R6: Cell 28 (V) carries `vbit_a` in left subframes and `vbit_b` in right subframes. Each is sampled on the clock edge that starts the subframe.
- R7: Cell 29 (U) carries user memory entry n and cell 30 (C) carries channel-status memory entry n, where n is the subframe number 0..383. The number returns from 383 to 0, together with the Z preamble.
- R8: Cell 31 makes the count of ones in cells 4 to 31 even.
- R9: `smp_ready` is high exactly while the holding register is empty. A pair is taken on a clock edge where `smp_valid` and `smp_ready` are both high. While the register is full, offered pairs are ignored. A held pair is consumed on the edge that starts the next left subframe.
- R10: If no pair is held when a left subframe starts, both subframes of that frame carry zero audio with V = 1. `underrun` is then high for the first clock of that left subframe only.
- R11: While reset is active, `line_out` is low, `smp_ready` is high and `underrun` is low. The first clock edge after reset starts subframe 0 with a Z preamble, and that first frame underruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the cell rate |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | Holding register is empty |
| smp_left | input | 24 | Left sample |
| smp_right | input | 24 | Right sample |
| vbit_a | input | 1 | V bit for left subframes |
| vbit_b | input | 1 | V bit for right subframes |
| cs_we | input | 1 | Channel-status memory write enable |
| cs_addr | input | 9 | Channel-status memory write index |
| cs_wdata | input | 1 | Channel-status bit to write |
| ud_we | input | 1 | User memory write enable |
| ud_addr | input | 9 | User memory write index |
| ud_wdata | input | 1 | User bit to write |
| line_out | output | 1 | Biphase-mark coded line |
| underrun | output | 1 | One-clock pulse when a frame starts with no sample |

## Verification
The assertions rely on a few things about the inputs. Every memory entry is written before the block reads it. The `vbit_a` and `vbit_b` levels, and an offered pair, stay steady across any clock edge where the block samples them. The assertions do not depend on when pairs arrive. The stimulus fills both memories while reset is held. It then changes the V levels and offers pairs only at the midpoint of right subframes, so every expected subframe field is fixed before the edge that samples it. Double offers test the full-register case, and skipped offers produce underruns in both isolated and back-to-back frames.

// File: rtl/spdif_pkg.sv
package spdif_pkg;
    localparam int SAMPLE_W   = 24;
    localparam int PRE_CELLS  = 4;
    localparam int AUX_CELLS  = 4;
    localparam int CELLS      = PRE_CELLS + SAMPLE_W + AUX_CELLS;
    localparam int HALVES     = 2 * CELLS;
    localparam int PRE_HALVES = 2 * PRE_CELLS;
    localparam int PAY_W      = SAMPLE_W + AUX_CELLS;
    localparam int HC_W       = $clog2(HALVES);

    typedef enum logic [1:0] {
        PRE_X = 2'd0,
        PRE_Y = 2'd1,
        PRE_Z = 2'd2
    } pre_t;

    // bit i is the level of half-cell i when the line was low before
    function automatic logic [7:0] pre_pattern(pre_t kind);
        logic [7:0] pat;
        case (kind)
            PRE_X:   pat = 8'b0100_0111;
            PRE_Y:   pat = 8'b0010_0111;
            default: pat = 8'b0001_0111;
        endcase
        return pat;
    endfunction
endpackage

// File: rtl/spdif_bitmem.sv
module spdif_bitmem #(
    parameter int DEPTH = 384,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            bits_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (int'(raddr) < DEPTH) ? bits_q[raddr] : 1'b0;
    end
endmodule

// File: rtl/spdif_slot_timer.sv
module spdif_slot_timer
    import spdif_pkg::*;
#(
    parameter int SLOTS = 384,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [HC_W-1:0] hc_q,
    output logic [SW-1:0]   slot_q,
    output logic [SW-1:0]   slot_next,
    output logic            sf_last
);
    typedef struct packed {
        logic [HC_W-1:0] hc;
        logic [SW-1:0]   slot;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        sf_last   = (cur_q.hc == HC_W'(HALVES - 1));
        slot_next = (cur_q.slot == SW'(SLOTS - 1)) ? '0 : cur_q.slot + 1'b1;
        nxt_d     = cur_q;
        nxt_d.hc  = cur_q.hc + 1'b1;
        if (sf_last) begin
            nxt_d.hc   = '0;
            nxt_d.slot = slot_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.hc   <= HC_W'(HALVES - 1);
            cur_q.slot <= SW'(SLOTS - 1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hc_q   = cur_q.hc;
    assign slot_q = cur_q.slot;

    p_slot_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.hc == '0 && $past(cur_q.slot) == SW'(SLOTS - 1)) |-> (cur_q.slot == '0));
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
    import spdif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HC_W-1:0]  hc_q,
    input  logic             sf_last,
    input  pre_t             pre_cur,
    input  pre_t             pre_next,
    input  logic [PAY_W-1:0] payload,
    output logic             line_out
);
    typedef struct packed {
        logic line;
        logic pol;
    } enc_t;

    enc_t cur_q, nxt_d;
    logic [7:0]      pat_c, pat_n;
    logic [HC_W-1:0] nh;
    logic [HC_W-2:0] pidx;
    logic [HC_W-2:0] pidx_now;

    always_comb begin
        pat_c    = pre_pattern(pre_cur);
        pat_n    = pre_pattern(pre_next);
        nh       = hc_q + 1'b1;
        pidx     = nh[HC_W-1:1] - (HC_W-1)'(PRE_CELLS);
        pidx_now = hc_q[HC_W-1:1] - (HC_W-1)'(PRE_CELLS);
        nxt_d    = cur_q;
        if (sf_last) begin
            nxt_d.pol  = cur_q.line;
            nxt_d.line = cur_q.line ^ pat_n[0];
        end else if (nh < HC_W'(PRE_HALVES)) begin
            nxt_d.line = cur_q.pol ^ pat_c[nh[2:0]];
        end else if (!nh[0]) begin
            nxt_d.line = ~cur_q.line;
        end else begin
            nxt_d.line = cur_q.line ^ payload[pidx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign line_out = cur_q.line;

    p_cell_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hc_q[0] && (hc_q == '0 || hc_q >= HC_W'(PRE_HALVES)))
        |-> (cur_q.line != $past(cur_q.line)));

    p_mid_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_q[0] && hc_q > HC_W'(PRE_HALVES))
        |-> ((cur_q.line != $past(cur_q.line)) == payload[pidx_now]));
endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
    import spdif_pkg::*;
#(
    parameter int SLOTS = 384,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                vbit_a,
    input  logic                vbit_b,
    input  logic                cs_we,
    input  logic [SW-1:0]       cs_addr,
    input  logic                cs_wdata,
    input  logic                ud_we,
    input  logic [SW-1:0]       ud_addr,
    input  logic                ud_wdata,
    output logic                line_out,
    output logic                underrun
);
    typedef struct packed {
        logic                buf_full;
        logic [SAMPLE_W-1:0] buf_l;
        logic [SAMPLE_W-1:0] buf_r;
        logic [SAMPLE_W-1:0] hold_r;
        logic                frame_uf;
        logic [PAY_W-1:0]    payload;
        pre_t                pre_cur;
        logic                uf_pulse;
    } st_t;

    st_t st_q, st_d;

    logic [HC_W-1:0] hc_q;
    logic [SW-1:0]   slot_q, slot_next;
    logic            sf_last;
    logic            cs_bit, ud_bit;
    pre_t            pre_next;

    spdif_slot_timer #(.SLOTS(SLOTS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hc_q      (hc_q),
        .slot_q    (slot_q),
        .slot_next (slot_next),
        .sf_last   (sf_last)
    );

    spdif_bitmem #(.DEPTH(SLOTS)) u_cs_mem (
        .clk   (clk),
        .we    (cs_we),
        .waddr (cs_addr),
        .wdata (cs_wdata),
        .raddr (slot_next),
        .rdata (cs_bit)
    );

    spdif_bitmem #(.DEPTH(SLOTS)) u_ud_mem (
        .clk   (clk),
        .we    (ud_we),
        .waddr (ud_addr),
        .wdata (ud_wdata),
        .raddr (slot_next),
        .rdata (ud_bit)
    );

    logic                accept;
    logic                nx_left;
    logic                nx_uf;
    logic                nx_v;
    logic [SAMPLE_W-1:0] nx_audio;

    always_comb begin
        accept   = smp_valid && !st_q.buf_full;
        nx_left  = !slot_next[0];
        pre_next = (slot_next == '0) ? PRE_Z : (nx_left ? PRE_X : PRE_Y);
        nx_uf    = nx_left ? !st_q.buf_full : st_q.frame_uf;
        nx_audio = nx_left ? (st_q.buf_full ? st_q.buf_l : '0)
                           : (st_q.frame_uf ? '0 : st_q.hold_r);
        nx_v     = nx_uf ? 1'b1 : (nx_left ? vbit_a : vbit_b);

        st_d          = st_q;
        st_d.uf_pulse = 1'b0;

        if (sf_last) begin
            st_d.pre_cur = pre_next;
            st_d.payload = {^{cs_bit, ud_bit, nx_v, nx_audio}, cs_bit, ud_bit, nx_v, nx_audio};
            if (nx_left) begin
                st_d.frame_uf = nx_uf;
                st_d.uf_pulse = nx_uf;
                st_d.hold_r   = st_q.buf_full ? st_q.buf_r : '0;
                st_d.buf_full = 1'b0;
            end
        end

        if (accept) begin
            st_d.buf_full = 1'b1;
            st_d.buf_l    = smp_left;
            st_d.buf_r    = smp_right;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.pre_cur <= PRE_Z;
        end else begin
            st_q <= st_d;
        end
    end

    spdif_bmc_enc u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hc_q     (hc_q),
        .sf_last  (sf_last),
        .pre_cur  (st_q.pre_cur),
        .pre_next (pre_next),
        .payload  (st_q.payload),
        .line_out (line_out)
    );

    assign smp_ready = !st_q.buf_full;
    assign underrun  = st_q.uf_pulse;

    p_accept_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);

    p_underrun_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (hc_q == '0 && !slot_q[0]));

    p_z_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_q == '0 && slot_q == '0) |-> (st_q.pre_cur == PRE_Z));

    p_parity_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_q == '0) |-> (^st_q.payload == 1'b0));
endmodule

// File: tb/tb_spdif_bmc_tx.sv
module tb_spdif_bmc_tx;
    localparam int NSF = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        vbit_a = 1'b0;
    logic        vbit_b = 1'b0;
    logic        cs_we = 1'b0;
    logic [8:0]  cs_addr = '0;
    logic        cs_wdata = 1'b0;
    logic        ud_we = 1'b0;
    logic [8:0]  ud_addr = '0;
    logic        ud_wdata = 1'b0;
    logic        line_out;
    logic        underrun;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    spdif_bmc_tx dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_left(smp_left), .smp_right(smp_right), .vbit_a(vbit_a), .vbit_b(vbit_b),
        .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata),
        .ud_we(ud_we), .ud_addr(ud_addr), .ud_wdata(ud_wdata),
        .line_out(line_out), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_pre(input int kind, input logic prev);
        logic [7:0] p;
        case (kind)
            0: p = 8'b0100_0111;
            1: p = 8'b0010_0111;
            default: p = 8'b0001_0111;
        endcase
        return prev ? ~p : p;
    endfunction

    logic [383:0] cs_m, ud_m;
    logic [63:0]  halves;
    logic         prev_lvl;
    logic         pend_v;
    logic [23:0]  pend_l, pend_r, cur_r, exp_audio;
    logic         frame_uf, exp_v;
    logic [27:0]  exp_pay, got_pay;
    bit           offer, dbl;

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        for (int i = 0; i < 384; i++) begin
            cs_m[i] = 1'($urandom);
            ud_m[i] = 1'($urandom);
        end
        cs_m[0] = 1'b1; ud_m[383] = 1'b1;
        for (int i = 0; i < 384; i++) begin
            @(negedge clk);
            cs_we = 1'b1; cs_addr = 9'(i); cs_wdata = cs_m[i];
            ud_we = 1'b1; ud_addr = 9'(i); ud_wdata = ud_m[i];
        end
        @(negedge clk);
        cs_we = 1'b0; ud_we = 1'b0;
        // R11: reset state
        chk(line_out == 1'b0, "R11 line low in reset", 32'(line_out), 0);
        chk(smp_ready == 1'b1, "R11 ready high in reset", 32'(smp_ready), 1);
        chk(underrun == 1'b0, "R11 underrun low in reset", 32'(underrun), 0);
        rst_n = 1'b1;

        prev_lvl = 1'b0; pend_v = 1'b0; cur_r = '0; frame_uf = 1'b1;
        exp_audio = '0; exp_v = 1'b1;
        for (int s = 0; s < NSF; s++) begin
            int slot, f, kind;
            bit left;
            slot = s % 384; f = s / 2; left = (s % 2) == 0;
            kind = (slot == 0) ? 2 : (left ? 0 : 1);
            if (left) begin
                if (pend_v) begin
                    frame_uf = 1'b0; exp_audio = pend_l; cur_r = pend_r; pend_v = 1'b0;
                end else begin
                    frame_uf = 1'b1; exp_audio = '0; cur_r = '0;
                end
                exp_v = frame_uf ? 1'b1 : vbit_a;
            end else begin
                exp_audio = frame_uf ? '0 : cur_r;
                exp_v = frame_uf ? 1'b1 : vbit_b;
            end
            exp_pay = {^{cs_m[slot], ud_m[slot], exp_v, exp_audio}, cs_m[slot], ud_m[slot], exp_v, exp_audio};

            for (int h = 0; h < 64; h++) begin
                @(negedge clk);
                halves[h] = line_out;
                if (h == 0 && left)
                    chk(underrun == frame_uf, "R10 underrun pulse at frame start", 32'(underrun), 32'(frame_uf));
                if (h == 1)
                    chk(underrun == 1'b0, "R10 underrun lasts one clock", 32'(underrun), 0);
                if (h == 32 && !left) begin
                    chk(smp_ready == 1'b1, "R9 ready while empty", 32'(smp_ready), 1);
                    offer = !(f == 0 || f == 10 || f == 11 || f == 100) && ($urandom % 8 != 0);
                    dbl = (f % 7) == 3;
                    vbit_a = 1'($urandom); vbit_b = 1'($urandom);
                    if (offer) begin
                        smp_left = 24'($urandom); smp_right = 24'($urandom);
                        if (f == 20) begin smp_left = 24'hFFFFFF; smp_right = 24'h800001; end
                        smp_valid = 1'b1;
                        pend_v = 1'b1; pend_l = smp_left; pend_r = smp_right;
                    end
                end
                if (h == 33 && !left) begin
                    chk(smp_ready == !offer, "R9 ready drops after accept", 32'(smp_ready), 32'(!offer));
                    if (offer && dbl) begin
                        smp_left = ~pend_l; smp_right = ~pend_r;
                    end else begin
                        smp_valid = 1'b0;
                    end
                end
                if (h == 34 && !left) begin
                    smp_valid = 1'b0;
                    chk(smp_ready == !offer, "R9 full register ignores offer", 32'(smp_ready), 32'(!offer));
                end
            end

            // decode
            begin
                bit edges_ok;
                edges_ok = halves[0] != prev_lvl;
                for (int c = 4; c < 32; c++) begin
                    if (halves[2*c] == halves[2*c-1]) edges_ok = 1'b0;
                    got_pay[c-4] = halves[2*c] ^ halves[2*c+1];
                end
                chk(edges_ok, "R1 cell boundary transitions", 32'(s), 32'(s));
                chk(halves[7:0] == exp_pre(kind, prev_lvl), (kind == 2) ? "R4 Z preamble at block start" : "R3 preamble pattern",
                    32'(halves[7:0]), 32'(exp_pre(kind, prev_lvl)));
                chk(got_pay == exp_pay, "R2 mid-cell coding of cells 4..31", 32'(got_pay), 32'(exp_pay));
                chk(got_pay[23:0] == exp_audio, "R5 audio LSB first", 32'(got_pay[23:0]), 32'(exp_audio));
                chk(got_pay[24] == exp_v, "R6 V bit", 32'(got_pay[24]), 32'(exp_v));
                chk(got_pay[26:25] == {cs_m[slot], ud_m[slot]}, "R7 C and U from memories", 32'(got_pay[26:25]),
                    32'({cs_m[slot], ud_m[slot]}));
                chk(^got_pay == 1'b0, "R8 even parity", 32'(^got_pay), 0);
                if (s == 0)
                    chk(frame_uf && halves[7:0] == 8'b0001_0111, "R11 first subframe Z and underrun", 32'(halves[7:0]), 32'h17);
                prev_lvl = halves[63];
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(5 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule